// File: doc/BRIEF.md
# Window-Select Funnel Shifter

This block shifts or rotates a data word by any amount in a single combinational pass. Its core joins two N-bit words into one 2N-bit field and passes through any N adjacent bits of that field. A one-hot select vector of N bits sets where the window starts. The core does not decide whether a shift is left, right or a rotate. That comes only from what is placed in each of the two halves: data in one half and zeros in the other gives a shift, and the same word in both halves gives a rotate.

The top module offers two paths. The raw path exposes the window core directly: two words, a one-hot select, the window output and a flag for a malformed select. The command path takes one data word, a binary shift amount and a two-bit operation code. A control stage turns these into load strobes for the two halves and a window position. A decoder turns that position into the one-hot select for a second copy of the core. N must be a power of two, at least 2.

Top module: `funnel_shifter`

## Requirements
- R1: With only select bit j set on the raw path, output bit i equals bit i+j of the 2N-bit field. In that field, `upperIn` sits at bits N-1..0 and `lowerIn` sits at bits 2N-1..N. So j = 0 passes `upperIn` unchanged.
- R2: When `winSel` has no bit set or more than one bit set, `winOut` is all zeros and `winErr` is 1. When exactly one bit is set, `winErr` is 0.
- R3: Operation code 2'b01 is a logical right shift. `dataOut` equals `dataIn` shifted right by `shiftAmt`, with zeros entering at the most significant end.
- R4: Operation code 2'b00 is a logical left shift. `dataOut` equals `dataIn` shifted left by `shiftAmt`, with zeros entering at bit 0.
- R5: Operation code 2'b10 is a rotate right. Bits leaving bit 0 re-enter at bit N-1, so `dataOut` bit i equals `dataIn` bit (i+`shiftAmt`) mod N.
- R6: Operation code 2'b11 is reserved. It drives `dataOut` to all zeros for every data word and every amount.
- R7: A shift amount of 0 returns `dataIn` unchanged for operation codes 2'b00, 2'b01 and 2'b10.
- R8: Every shift amount from 0 to N-1, on both paths, settles combinationally. No clock edge is involved, and the result matches R1 through R7 for N = 8 and for N = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| upperIn | input | N | Raw path: half shown at window position 0 |
| lowerIn | input | N | Raw path: half that fills in as the window moves up |
| winSel | input | N | Raw path: one-hot window position |
| winOut | output | N | Raw path: selected N-bit window |
| winErr | output | 1 | Raw path: select is not one-hot |
| dataIn | input | N | Command path: word to shift or rotate |
| shiftAmt | input | log2(N) | Command path: binary shift amount |
| opCode | input | 2 | Command path: 00 left, 01 right, 10 rotate right, 11 reserved |
| dataOut | output | N | Command path: result |

## Verification
Both paths are purely combinational, so each result is due in the same evaluation as its stimulus, zero cycles later. The bench drives inputs on the falling clock edge. It reads the outputs one nanosecond later, well before the next rising edge, so a result is never read while the inputs are changing. The 8-bit instance gets every select value on the raw path and every operation and amount on the command path. The 32-bit instance gets every single-bit select, the empty select, pairs of set bits, and every operation and amount. Expected words come from shift operators written in the bench.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHR  = 2'b01,
    OP_ROR  = 2'b10,
    OP_RSVD = 2'b11
  } funnelOp_e;

  // Strobes from control to datapath: which half receives the data word.
  typedef struct packed {
    logic upperTakesData;
    logic lowerTakesData;
  } loadStrobe_t;

endpackage

// File: rtl/funnel_ctrl.sv
module funnel_ctrl
  import funnel_pkg::*;
#(
  parameter int N = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] shiftAmt,
  input  logic [1:0]    opCode,
  output loadStrobe_t   loadStb,
  output logic [AW-1:0] winIdx
);

  funnelOp_e opSel;
  logic      amtIsZero;

  assign opSel     = funnelOp_e'(opCode);
  assign amtIsZero = (shiftAmt == '0);

  always_comb begin
    loadStb = '0;
    winIdx  = '0;
    unique case (opSel)
      OP_SHR: begin
        // Data in the half seen at position 0; zeros fill from the other half.
        loadStb.upperTakesData = 1'b1;
        winIdx                 = shiftAmt;
      end
      OP_ROR: begin
        loadStb.upperTakesData = 1'b1;
        loadStb.lowerTakesData = 1'b1;
        winIdx                 = shiftAmt;
      end
      OP_SHL: begin
        // A left shift by k is the window at N-k over {data, zeros}.
        // For k = 0 that position wraps to 0, which shows the upper half.
        loadStb.lowerTakesData = 1'b1;
        loadStb.upperTakesData = amtIsZero;
        winIdx                 = AW'((N - int'(shiftAmt)) % N);
      end
      default: begin
        loadStb = '0;
        winIdx  = '0;
      end
    endcase
  end

  always_comb begin
    if (opSel == OP_RSVD) begin
      AST_RSVD_NO_LOAD: assert (loadStb == '0) else $error("reserved op loaded data"); // R6
    end
    if (opSel == OP_SHR && !amtIsZero) begin
      AST_SHR_LOWER_ZERO: assert (!loadStb.lowerTakesData) else $error("right shift loaded fill half"); // R3
    end
  end

endmodule

// File: rtl/funnel_sel_decode.sv
module funnel_sel_decode #(
  parameter int N = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] winIdx,
  output logic [N-1:0]  winSel
);

  for (genvar j = 0; j < N; j++) begin : g_dec
    assign winSel[j] = (winIdx == AW'(j));
  end

  always_comb begin
    AST_DEC_ONE_HOT: assert ($onehot(winSel)) else $error("decoded select not one-hot"); // R8
  end

endmodule

// File: rtl/funnel_window.sv
module funnel_window #(
  parameter int N = 8
) (
  input  logic [N-1:0] upperWord,
  input  logic [N-1:0] lowerWord,
  input  logic [N-1:0] winSel,
  output logic [N-1:0] winOut,
  output logic         winErr
);

  localparam int FW = 2 * N;

  logic [FW-1:0] fieldW;
  logic [N-1:0]  termW [N];
  logic [N-1:0]  orAcc;
  logic          anyHit;
  logic          multiHit;

  assign fieldW = {lowerWord, upperWord};

  // One column per window position: gate that slice of the field onto the output bus.
  for (genvar j = 0; j < N; j++) begin : g_col
    assign termW[j] = winSel[j] ? fieldW[j +: N] : '0;
  end

  always_comb begin
    orAcc    = '0;
    anyHit   = 1'b0;
    multiHit = 1'b0;
    for (int j = 0; j < N; j++) begin
      orAcc    = orAcc | termW[j];
      multiHit = multiHit | (anyHit & winSel[j]);
      anyHit   = anyHit | winSel[j];
    end
  end

  assign winErr = !anyHit || multiHit;
  assign winOut = winErr ? '0 : orAcc;

  always_comb begin
    AST_ERR_MATCHES_SEL: assert (winErr == !$onehot(winSel)) else $error("error flag disagrees with select"); // R2
    if (winErr) begin
      AST_ERR_BLANKS_OUT: assert (winOut == '0) else $error("output not blank on bad select"); // R2
    end
    if (winSel == N'(1)) begin
      AST_POS0_UPPER: assert (winOut == upperWord) else $error("position 0 must pass upper half"); // R1
    end
  end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_pkg::*;
#(
  parameter int N = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  upperIn,
  input  logic [N-1:0]  lowerIn,
  input  logic [N-1:0]  winSel,
  output logic [N-1:0]  winOut,
  output logic          winErr,
  input  logic [N-1:0]  dataIn,
  input  logic [AW-1:0] shiftAmt,
  input  logic [1:0]    opCode,
  output logic [N-1:0]  dataOut
);

  // Raw path: the window core on its own.
  funnel_window #(.N(N)) u_rawWin (
    .upperWord (upperIn),
    .lowerWord (lowerIn),
    .winSel    (winSel),
    .winOut    (winOut),
    .winErr    (winErr)
  );

  // Command path: control, decode and a second core.
  loadStrobe_t   loadStb;
  logic [AW-1:0] cmdIdx;
  logic [N-1:0]  cmdSel;
  logic [N-1:0]  cmdUpper;
  logic [N-1:0]  cmdLower;
  logic          cmdErr;

  funnel_ctrl #(.N(N)) u_ctrl (
    .shiftAmt (shiftAmt),
    .opCode   (opCode),
    .loadStb  (loadStb),
    .winIdx   (cmdIdx)
  );

  funnel_sel_decode #(.N(N)) u_dec (
    .winIdx (cmdIdx),
    .winSel (cmdSel)
  );

  assign cmdUpper = loadStb.upperTakesData ? dataIn : '0;
  assign cmdLower = loadStb.lowerTakesData ? dataIn : '0;

  funnel_window #(.N(N)) u_cmdWin (
    .upperWord (cmdUpper),
    .lowerWord (cmdLower),
    .winSel    (cmdSel),
    .winOut    (dataOut),
    .winErr    (cmdErr)
  );

  always_comb begin
    AST_CMD_SEL_OK: assert (!cmdErr) else $error("command path produced bad select"); // R8
    if (shiftAmt == '0 && opCode != 2'b11) begin
      AST_ZERO_AMT_PASS: assert (dataOut == dataIn) else $error("zero amount altered data"); // R7
    end
    if (opCode == 2'b10) begin
      AST_ROT_WEIGHT: assert ($countones(dataOut) == $countones(dataIn)) else $error("rotate changed bit count"); // R5
    end
    if (opCode == 2'b01 && shiftAmt != '0) begin
      AST_SHR_TOP_ZERO: assert (dataOut[N-1] == 1'b0) else $error("right shift top bit not zero"); // R3
    end
    if (opCode == 2'b00 && shiftAmt != '0) begin
      AST_SHL_LOW_ZERO: assert (dataOut[0] == 1'b0) else $error("left shift low bit not zero"); // R4
    end
    if (opCode == 2'b11) begin
      AST_RSVD_ZERO: assert (dataOut == '0) else $error("reserved op gave nonzero"); // R6
    end
  end

endmodule

// File: tb/sim_funnel_shifter.sv
`timescale 1ns/1ps
module sim_funnel_shifter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // 8-bit instance
  logic [7:0]  upper8, lower8, sel8, win8, din8, dout8;
  logic        err8;
  logic [2:0]  amt8;
  logic [1:0]  op8;
  // 32-bit instance
  logic [31:0] upper32, lower32, sel32, win32, din32, dout32;
  logic        err32;
  logic [4:0]  amt32;
  logic [1:0]  op32;

  funnel_shifter #(.N(8)) u0 (
    .upperIn(upper8), .lowerIn(lower8), .winSel(sel8), .winOut(win8), .winErr(err8),
    .dataIn(din8), .shiftAmt(amt8), .opCode(op8), .dataOut(dout8)
  );

  funnel_shifter #(.N(32)) u1 (
    .upperIn(upper32), .lowerIn(lower32), .winSel(sel32), .winOut(win32), .winErr(err32),
    .dataIn(din32), .shiftAmt(amt32), .opCode(op32), .dataOut(dout32)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] maskOf(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] refCmd(input int n, input logic [63:0] d, input int k, input logic [1:0] op);
    logic [63:0] m = maskOf(n);
    logic [63:0] v = d & m;
    case (op)
      2'b00:   return (v << k) & m;
      2'b01:   return v >> k;
      2'b10:   return ((v >> k) | (v << (n - k))) & m;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] refWin(input int n, input logic [63:0] up, input logic [63:0] lo, input logic [63:0] sel);
    int ones = 0;
    int pos = 0;
    logic [63:0] m = maskOf(n);
    logic [127:0] field;
    for (int j = 0; j < n; j++) if (sel[j]) begin ones++; pos = j; end
    if (ones != 1) return 64'd0;
    field = ({64'd0, lo & m} << n) | {64'd0, up & m};
    return 64'(field >> pos) & m;
  endfunction

  function automatic string tagOf(input logic [1:0] op, input int k);
    if (op == 2'b11) return "R6 reserved";
    if (k == 0) return "R7 zero amount";
    case (op)
      2'b00:   return "R4 left";
      2'b01:   return "R3 right";
      default: return "R5 rotate";
    endcase
  endfunction

  // Watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats[4];
    upper8 = '0; lower8 = '0; sel8 = '0; din8 = '0; amt8 = '0; op8 = '0;
    upper32 = '0; lower32 = '0; sel32 = '0; din32 = '0; amt32 = '0; op32 = '0;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // Idle state: empty select, zero data
    check("R2 idle out8", {56'd0, win8}, 64'd0);
    check("R2 idle err8", {63'd0, err8}, 64'd1);
    check("R2 idle err32", {63'd0, err32}, 64'd1);
    check("R4 idle dout8", {56'd0, dout8}, 64'd0);

    // Command path, N = 8: all ops, all amounts
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 8; k++) begin
        pats[0] = 64'hFF; pats[1] = 64'h01; pats[2] = 64'h80; pats[3] = 64'(($urandom & 32'hFF) | 32'h01);
        for (int p = 0; p < 8; p++) begin
          @(negedge clk);
          din8 = (p < 4) ? pats[p][7:0] : 8'($urandom);
          amt8 = 3'(k); op8 = 2'(op);
          #1;  // R8: no clock edge between drive and sample
          check(tagOf(2'(op), k), {56'd0, dout8}, refCmd(8, {56'd0, din8}, k, 2'(op)));
        end
      end
    end

    // Command path, N = 32
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 32; k++) begin
        for (int p = 0; p < 4; p++) begin
          @(negedge clk);
          din32 = (p == 0) ? 32'hFFFF_FFFF : $urandom;
          amt32 = 5'(k); op32 = 2'(op);
          #1;
          check({tagOf(2'(op), k), " R8 n32"}, {32'd0, dout32}, refCmd(32, {32'd0, din32}, k, 2'(op)));
        end
      end
    end

    // Raw path, N = 8: every select value
    for (int s = 0; s < 256; s++) begin
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        sel8 = 8'(s); upper8 = 8'($urandom); lower8 = 8'($urandom);
        #1;
        check("R1 window n8", {56'd0, win8}, refWin(8, {56'd0, upper8}, {56'd0, lower8}, {56'd0, sel8}));
        check("R2 flag n8", {63'd0, err8}, {63'd0, ($countones(sel8) != 1)});
      end
    end

    // Raw path, N = 32: single bits, empty, pairs
    for (int j = 0; j < 32; j++) begin
      for (int i = j; i < 32; i++) begin
        @(negedge clk);
        sel32 = (32'd1 << j) | (32'd1 << i);
        upper32 = $urandom; lower32 = $urandom;
        #1;
        check("R1 R2 window n32", {32'd0, win32}, refWin(32, {32'd0, upper32}, {32'd0, lower32}, {32'd0, sel32}));
        check("R2 flag n32", {63'd0, err32}, {63'd0, (i != j)});
      end
    end
    @(negedge clk);
    sel32 = '0; upper32 = 32'hDEAD_BEEF; lower32 = 32'h1234_5678;
    #1;
    check("R2 empty n32", {32'd0, win32}, 64'd0);
    check("R2 empty flag n32", {63'd0, err32}, 64'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule